// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This peripheral groups general-purpose pins into banks of 32 and puts each bank behind a plain 32-bit register bus. Software picks the direction of every pin. It drives outputs either by writing the whole output word or through write-one set and clear strobes, which change only the chosen bits. It can read the pin levels at any time. Pin inputs pass through a two-stage synchroniser. Rising and falling edges of the synchronised level can each be armed per pin, and an armed edge latches a status bit. Software clears that bit by writing a one to it.

The status bits of each bank split into two groups of 16. Each group drives its own level interrupt line. A global enable register gates every line with one bit. Pins appear as three vectors: the level in, the driven value out, and the drive enable. Pad logic lives outside the block.

The block has no sequencing state machine. All of its behaviour sits in per-bank register state (direction, output word, the two edge-enable masks, status), the synchroniser pipeline with its previous-level register, and a registered read port.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` all 0), `pin_out` is 0, the edge enables, status bits and global enable register are 0, `irq` is 0, and the direction register reads all ones.
- R2: The direction register at bank offset 0x00 holds 1 for an input and 0 for an output. `pin_oe` is its bitwise inverse one cycle after the write, and it reads back as written.
- R3: The output word at bank offset 0x04 is written directly, reads back as stored, and appears on `pin_out` one cycle after the write.
- R4: A write to bank offset 0x08 sets the output bits where the data has ones. A write to offset 0x0C clears them. Bits written as zero keep their value.
- R5: Bank offset 0x10 returns the pin level after the two-flop synchroniser, for output pins as well. A read issued in the cycle right after a pin change returns the old level. Writes to this offset change nothing.
- R6: Rising-edge enables are set through offset 0x14 and cleared through 0x18. Falling-edge enables are set through 0x1C and cleared through 0x20. Reading either offset of a pair returns that enable mask.
- R7: A rising edge on a pin with its rising enable set, or a falling edge on a pin with its falling enable set, sets that pin's bit in the status register at offset 0x24. With both enables set, either edge sets it. No status bit is set without such an edge.
- R8: Writing 1 to a status bit clears it. Status bits written as 0 are unaffected.
- R9: When a qualifying edge and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq[2b]` is high when global enable bit 2b is set and any of status bits 15:0 of bank b is set. `irq[2b+1]` does the same for bits 31:16 with enable bit 2b+1. The global enable register sits at address 0x08 and reads back.
- R11: Bank b's registers start at 0x10 + 0x28*b. Reads of unmapped addresses return 0, and banks do not disturb each other.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32*NUM_BANKS | Pin levels from the pads |
| pin_out | output | 32*NUM_BANKS | Output values to the pads |
| pin_oe | output | 32*NUM_BANKS | Drive enables, 1 = driving |
| irq | output | 2*NUM_BANKS | Level interrupt per 16-pin group |

## Verification
Two functions can meet in the same cycle: edge capture and the write-one-to-clear of the status register. The bench clears a status bit and arms the rising edge of that pin. It raises the pin, then times a clearing write so that it is sampled at the exact edge where the synchronised level first differs from its previous value. The judgment is a status readback that must still show the bit set. A plain clearing write afterwards must then remove it.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int BANK_W        = 32;
    localparam int IRQ_GRP_W     = 16;
    localparam int BANK_BASE     = 16;
    localparam int BANK_STRIDE   = 40;
    localparam int GLOBAL_EN_ADR = 8;
    localparam int REG_IDX_W     = 4;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_DIR      = 4'd0,
        REG_OUT      = 4'd1,
        REG_OUT_SET  = 4'd2,
        REG_OUT_CLR  = 4'd3,
        REG_IN       = 4'd4,
        REG_RISE_SET = 4'd5,
        REG_RISE_CLR = 4'd6,
        REG_FALL_SET = 4'd7,
        REG_FALL_CLR = 4'd8,
        REG_STAT     = 4'd9
    } reg_idx_e;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [W-1:0]         wdata,
    input  logic [W-1:0]         pin_in,
    output logic [W-1:0]         rd_word,
    output logic [W-1:0]         pin_out,
    output logic [W-1:0]         pin_oe,
    output logic [W/IRQ_GRP_W-1:0] grp_pend
);

    localparam int GROUPS = W / IRQ_GRP_W;

    reg_idx_e     sel;
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] rise_en_q;
    logic [W-1:0] fall_en_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] sync_lvl;
    logic [W-1:0] prev_lvl;
    logic [W-1:0] edge_hit;
    logic [W-1:0] clr_mask;

    assign sel = reg_idx_e'(reg_idx);

    pio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= sync_lvl;
    end

    assign edge_hit = (sync_lvl & ~prev_lvl & rise_en_q)
                    | (~sync_lvl & prev_lvl & fall_en_q);

    // configuration and output state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '1;
            out_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                REG_DIR:      dir_q     <= wdata;
                REG_OUT:      out_q     <= wdata;
                REG_OUT_SET:  out_q     <= out_q | wdata;
                REG_OUT_CLR:  out_q     <= out_q & ~wdata;
                REG_RISE_SET: rise_en_q <= rise_en_q | wdata;
                REG_RISE_CLR: rise_en_q <= rise_en_q & ~wdata;
                REG_FALL_SET: fall_en_q <= fall_en_q | wdata;
                REG_FALL_CLR: fall_en_q <= fall_en_q & ~wdata;
                default: ;
            endcase
        end
    end

    // status: new edges take priority over a same-cycle clear
    assign clr_mask = (wr_en && sel == REG_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | edge_hit;
    end

    always_comb begin
        rd_word = '0;
        unique case (sel)
            REG_DIR:                    rd_word = dir_q;
            REG_OUT, REG_OUT_SET,
            REG_OUT_CLR:                rd_word = out_q;
            REG_IN:                     rd_word = sync_lvl;
            REG_RISE_SET, REG_RISE_CLR: rd_word = rise_en_q;
            REG_FALL_SET, REG_FALL_CLR: rd_word = fall_en_q;
            REG_STAT:                   rd_word = stat_q;
            default:                    rd_word = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_pend[g] = |stat_q[g*IRQ_GRP_W +: IRQ_GRP_W];
    end

    // R2: direction write reaches the drive enables one cycle later
    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DIR) |=> (pin_oe == ~$past(wdata)));

    // R4: set strobe raises selected bits and keeps the rest
    assert_set_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_OUT_SET) |=>
            (((pin_out & $past(wdata)) == $past(wdata)) &&
             ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata)))));

    // R4: clear strobe lowers selected bits and keeps the rest
    assert_clr_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_OUT_CLR) |=>
            (((pin_out & $past(wdata)) == '0) &&
             ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata)))));

    // R9: a detected edge always leaves its status bit set
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

    // R7: status bits only rise where an armed edge was seen
    assert_no_spurious_stat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat_q & ~$past(stat_q)) & ~$past(edge_hit)) == '0));

endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
    import pio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [BANK_W*NUM_BANKS-1:0]    pin_in,
    output logic [BANK_W*NUM_BANKS-1:0]    pin_out,
    output logic [BANK_W*NUM_BANKS-1:0]    pin_oe,
    output logic [2*NUM_BANKS-1:0]         irq
);

    localparam int GROUPS    = BANK_W / IRQ_GRP_W;
    localparam int NIRQ      = GROUPS * NUM_BANKS;
    localparam int BANK_SPAN = BANK_STRIDE;

    logic [NUM_BANKS-1:0] bank_hit;
    logic [31:0]          bank_rd [NUM_BANKS];
    logic [NIRQ-1:0]      grp_pend;
    logic [NIRQ-1:0]      bank_en_q;
    logic                 en_sel;
    logic [31:0]          rd_next;

    assign en_sel = (bus_addr == ADDR_W'(GLOBAL_EN_ADR));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BANK_BASE + b * BANK_STRIDE);
        logic [ADDR_W-1:0]    offs;
        logic [REG_IDX_W-1:0] idx;

        assign offs        = bus_addr - BASE;
        assign idx         = REG_IDX_W'(offs >> 2);
        assign bank_hit[b] = (bus_addr >= BASE) && (offs < ADDR_W'(BANK_SPAN))
                             && (bus_addr[1:0] == 2'b00);

        pio_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && bank_hit[b]),
            .reg_idx  (idx),
            .wdata    (bus_wdata),
            .pin_in   (pin_in[b*BANK_W +: BANK_W]),
            .rd_word  (bank_rd[b]),
            .pin_out  (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe   (pin_oe[b*BANK_W +: BANK_W]),
            .grp_pend (grp_pend[b*GROUPS +: GROUPS])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bank_en_q <= '0;
        else if (bus_wr && en_sel) bank_en_q <= bus_wdata[NIRQ-1:0];
    end

    assign irq = grp_pend & bank_en_q;

    always_comb begin
        rd_next = '0;
        if (en_sel) rd_next = 32'(bank_en_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) rd_next = bank_rd[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // R10: clearing the global enable silences every line next cycle
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && en_sel && bus_wdata[NIRQ-1:0] == '0) |=> (irq == '0));

    // R12: read data only changes after a sampled read strobe
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/pio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module pio_edge_ctrl_tb;

    localparam int NB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [32*NB-1:0] pin_in = '0;
    logic [32*NB-1:0] pin_out;
    logic [32*NB-1:0] pin_oe;
    logic [2*NB-1:0]  irq;

    int compared = 0;
    int mismatched = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    pio_edge_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: pushes the expected word, monitor pops it when data returns
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", 64'(pin_oe), 64'h0);
        chk("R1 pin_out", 64'(pin_out), 64'h0);
        chk("R1 irq", 64'(irq), 64'h0);
        rd(8'h10, 32'hFFFF_FFFF, "R1 dir reset");
        rd(8'h34, 32'h0, "R1 status reset");
        rd(8'h08, 32'h0, "R1 global enable reset");
        rd(8'h24, 32'h0, "R1 rise enable reset");

        // R2 direction
        wr(8'h10, 32'hFFFF_0000);
        chk("R2 pin_oe", 64'(pin_oe[31:0]), 64'h0000_FFFF);
        rd(8'h10, 32'hFFFF_0000, "R2 dir readback");

        // R3 output word
        wr(8'h14, 32'h1234_5678);
        chk("R3 pin_out", 64'(pin_out[31:0]), 64'h1234_5678);
        rd(8'h14, 32'h1234_5678, "R3 out readback");

        // R4 set/clear strobes
        wr(8'h18, 32'h0000_000F);
        chk("R4 set", 64'(pin_out[31:0]), 64'h1234_567F);
        wr(8'h1C, 32'h1200_0000);
        chk("R4 clr", 64'(pin_out[31:0]), 64'h0034_567F);

        // R11 second bank independent
        wr(8'h3C, 32'hA5A5_A5A5);
        rd(8'h3C, 32'hA5A5_A5A5, "R11 bank1 out");
        chk("R11 bank0 untouched", 64'(pin_out[31:0]), 64'h0034_567F);
        chk("R11 bank1 pins", 64'(pin_out[63:32]), 64'hA5A5_A5A5);
        rd(8'h00, 32'h0, "R11 unmapped low");
        rd(8'h60, 32'h0, "R11 unmapped high");

        // R5 input register
        @(negedge clk); pin_in[31:0] = 32'hCAFE_F00D;
        settle();
        rd(8'h20, 32'hCAFE_F00D, "R5 input level");
        wr(8'h20, 32'h0);
        rd(8'h20, 32'hCAFE_F00D, "R5 write ignored");
        @(negedge clk); pin_in[31:0] = 32'h0;
        exp_q.push_back(32'hCAFE_F00D);
        tag_q.push_back("R5 stale readback");
        bus_rd = 1'b1; bus_addr = 8'h20;
        @(negedge clk); bus_rd = 1'b0;
        settle();
        rd(8'h20, 32'h0, "R5 new level");

        // R6/R7/R8 edge detection
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0000_0005);
        wr(8'h2C, 32'h0000_0006);
        rd(8'h24, 32'h5, "R6 rise mask");
        rd(8'h2C, 32'h6, "R6 fall mask");
        @(negedge clk); pin_in[2:0] = 3'b111;
        settle();
        rd(8'h34, 32'h5, "R7 rising edges");
        wr(8'h34, 32'h1);
        rd(8'h34, 32'h4, "R8 partial clear");
        wr(8'h34, 32'h4);
        @(negedge clk); pin_in[2:0] = 3'b000;
        settle();
        rd(8'h34, 32'h6, "R7 falling edges");
        wr(8'h34, 32'h6);
        wr(8'h28, 32'h4);
        rd(8'h28, 32'h1, "R6 rise clear");

        // R10 interrupt grouping and gating
        wr(8'h24, 32'h0010_0000);
        @(negedge clk); pin_in[20] = 1'b1;
        settle();
        chk("R10 gated off", 64'(irq), 64'h0);
        wr(8'h08, 32'h2);
        chk("R10 upper group", 64'(irq), 64'h2);
        wr(8'h08, 32'h1);
        chk("R10 other group", 64'(irq), 64'h0);
        wr(8'h08, 32'h3);
        wr(8'h34, 32'h0010_0000);
        chk("R10 cleared", 64'(irq), 64'h0);

        // R9 edge and clear in the same cycle
        wr(8'h24, 32'h0000_0020);
        @(negedge clk); pin_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h20;
        @(negedge clk); bus_wr = 1'b0;
        rd(8'h34, 32'h20, "R9 edge wins");
        wr(8'h34, 32'h20);
        rd(8'h34, 32'h0, "R8 clear after collision");

        // R10/R11 bank 1 lower group
        wr(8'h4C, 32'h1);
        @(negedge clk); pin_in[32] = 1'b1;
        settle();
        rd(8'h5C, 32'h1, "R11 bank1 status");
        wr(8'h08, 32'h4);
        chk("R10 bank1 line", 64'(irq), 64'h4);
        rd(8'h08, 32'h4, "R10 enable readback");

        settle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule